// File: doc/BRIEF.md
# Address-Match Breakpoint Generator

This block watches the address a processor presents and stops the processor for a debugger when that address equals one of four programmed values. Each of the four match sets holds a 24-bit address. A debug host loads the address through a byte-wide write port, and one control byte carries the enable bit for every set. An enabled set whose address equals the compared address counts as a hit. The hits of all enabled sets are ORed into a single break request. The request places the processor in debug mode, where it waits for the host.

The compared address depends on the processor's addressing mode. In the 24-bit linear mode the whole address bus is used. In the 16-bit compatibility mode the compared address is a page-base byte placed above the low 16 bits of the bus.

The time the break takes effect depends on the access that matched. A match on the first opcode fetch of an instruction raises the break at once, so the instruction never runs. Any other match is held back until the processor signals the end of the current instruction.

The request and the per-set hit flags stay latched until the host acknowledges them.

Top module: `addr_break_unit`

## Requirements
- R1: Set s (0..3) has its low, high and upper address bytes at write offsets 3s, 3s+1 and 3s+2. A write to one byte leaves the other bytes of that set unchanged.
- R2: The control byte is at offset 12, and bit s enables set s. A disabled set never hits. Writes to offsets 13 to 15 change nothing.
- R3: Reset clears every address byte, the control byte, the break request, the hit flags and any deferred break.
- R4: With linearMode=1, all 24 bits of cpuAddr are compared with the set's address.
- R5: With linearMode=0, the compared address is {pageBase, cpuAddr[15:0]}, and cpuAddr[23:16] is ignored.
- R6: An enabled match in a cycle with firstFetch=1 raises brkReq on the next clock edge.
- R7: An enabled match with firstFetch=0 is deferred. brkReq rises on the clock edge after the first cycle with instrEnd=1, and that cycle may be the match cycle itself.
- R8: The match results of the enabled sets are ORed. Bit s of hitStatus reports every set s that matched between the arming match and the break, and hitStatus is nonzero whenever brkReq is high.
- R9: brkReq and hitStatus hold until brkAck is seen while brkReq is high. One clock edge later both read zero.
- R10: While a break is pending, further matches merge into the same single request. While brkReq is high, matches are ignored and leave no break behind after the acknowledge.
- R11: Reset cancels a deferred break, so a later instrEnd raises nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register write offset |
| regWrData | input | 8 | Register write data |
| cpuAddr | input | 24 | Processor address bus |
| linearMode | input | 1 | 1 = 24-bit linear mode, 0 = 16-bit compatibility mode |
| pageBase | input | 8 | Page-base byte used in compatibility mode |
| firstFetch | input | 1 | The current access is the first opcode fetch of an instruction |
| instrEnd | input | 1 | The current instruction completes in this cycle |
| brkAck | input | 1 | Debug host acknowledge of the break |
| brkReq | output | 1 | Break request to the processor |
| hitStatus | output | 4 | Latched hit flag for each set |

## Verification
The assertions check the timing rules on every cycle:
- a first-fetch match breaks on the next edge;
- a deferred match with no instruction end leaves brkReq low;
- brkReq holds until it is acknowledged and falls after the acknowledge;
- the hit flags are nonzero while a break is raised and are cleared when it drops.

Other behaviour can be shown only by the bench's scenarios: the register offsets, the two ways of forming the compared address, the enable gating, the merging of hits across sets, and the cancelling of a deferred break by reset.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int NUM_SETS      = 4;
  localparam int BYTE_W        = 8;
  localparam int ADDR_W        = 24;
  localparam int SEG_W         = 16;
  localparam int BYTES_PER_SET = ADDR_W / BYTE_W;
  localparam int CTL_OFS       = NUM_SETS * BYTES_PER_SET;
  localparam int REG_AW        = $clog2(CTL_OFS + 1);

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_SETS-1:0][BYTES_PER_SET-1:0] wrByte;
    logic                                   wrCtl;
    logic                                   accum;
    logic                                   fire;
    logic                                   clear;
  } brkStrobe_t;
endpackage

// File: rtl/brk_datapath.sv
module brk_datapath
  import brk_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  brkStrobe_t          strb,
  input  logic [BYTE_W-1:0]   wrData,
  input  logic [ADDR_W-1:0]   cpuAddr,
  input  logic                linearMode,
  input  logic [BYTE_W-1:0]   pageBase,
  output logic                anyMatch,
  output logic [NUM_SETS-1:0] hitFlags
);
  localparam int PAGE_W = ADDR_W - SEG_W;

  logic [ADDR_W-1:0]   addrReg [NUM_SETS];
  logic [NUM_SETS-1:0] enableReg;
  logic [NUM_SETS-1:0] matchVec;
  logic [NUM_SETS-1:0] pendHits;
  logic [ADDR_W-1:0]   cmpAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SETS; s++) addrReg[s] <= '0;
      enableReg <= '0;
    end else begin
      for (int s = 0; s < NUM_SETS; s++)
        for (int b = 0; b < BYTES_PER_SET; b++)
          if (strb.wrByte[s][b]) addrReg[s][b*BYTE_W +: BYTE_W] <= wrData;
      if (strb.wrCtl) enableReg <= wrData[NUM_SETS-1:0];
    end
  end

  always_comb begin
    if (linearMode) cmpAddr = cpuAddr;
    else            cmpAddr = {pageBase[PAGE_W-1:0], cpuAddr[SEG_W-1:0]};
  end

  genvar gs;
  generate
    for (gs = 0; gs < NUM_SETS; gs++) begin : g_cmp
      assign matchVec[gs] = enableReg[gs] && (cmpAddr == addrReg[gs]);
    end
  endgenerate

  assign anyMatch = |matchVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendHits <= '0;
      hitFlags <= '0;
    end else begin
      if (strb.fire) begin
        hitFlags <= pendHits | matchVec;
        pendHits <= '0;
      end else begin
        if (strb.clear) hitFlags <= '0;
        if (strb.accum) pendHits <= pendHits | matchVec;
      end
    end
  end
endmodule

// File: rtl/brk_control.sv
module brk_control
  import brk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              anyMatch,
  input  logic              firstFetch,
  input  logic              instrEnd,
  input  logic              brkAck,
  output brkStrobe_t        strb,
  output logic              brkReq
);
  logic pending;

  always_comb begin
    strb = '0;
    for (int s = 0; s < NUM_SETS; s++)
      for (int b = 0; b < BYTES_PER_SET; b++)
        strb.wrByte[s][b] = regWrEn && (int'(regAddr) == s * BYTES_PER_SET + b);
    strb.wrCtl = regWrEn && (int'(regAddr) == CTL_OFS);
    strb.clear = brkReq && brkAck;
    if (!brkReq) begin
      if (anyMatch && firstFetch)      strb.fire  = 1'b1;
      else if (pending || anyMatch) begin
        if (instrEnd)                  strb.fire  = 1'b1;
        else                           strb.accum = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      brkReq  <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (strb.fire)       brkReq <= 1'b1;
      else if (strb.clear) brkReq <= 1'b0;
      if (strb.fire)       pending <= 1'b0;
      else if (strb.accum) pending <= 1'b1;
    end
  end

  // R6
  first_fetch_break_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyMatch && firstFetch && !brkReq |=> brkReq);
  // R7
  deferred_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyMatch && !firstFetch && !instrEnd && !brkReq |=> !brkReq);
  // R9
  break_latched_chk: assert property (@(posedge clk) disable iff (!rstN)
    brkReq && !brkAck |=> brkReq);
  // R9
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    brkReq && brkAck |=> !brkReq);
endmodule

// File: rtl/addr_break_unit.sv
module addr_break_unit
  import brk_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic [BYTE_W-1:0]   regWrData,
  input  logic [ADDR_W-1:0]   cpuAddr,
  input  logic                linearMode,
  input  logic [BYTE_W-1:0]   pageBase,
  input  logic                firstFetch,
  input  logic                instrEnd,
  input  logic                brkAck,
  output logic                brkReq,
  output logic [NUM_SETS-1:0] hitStatus
);
  brkStrobe_t strb;
  logic       anyMatch;

  brk_control u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .anyMatch(anyMatch), .firstFetch(firstFetch), .instrEnd(instrEnd),
    .brkAck(brkAck), .strb(strb), .brkReq(brkReq)
  );

  brk_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(regWrData),
    .cpuAddr(cpuAddr), .linearMode(linearMode), .pageBase(pageBase),
    .anyMatch(anyMatch), .hitFlags(hitStatus)
  );

  // R8
  hits_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    brkReq |-> hitStatus != '0);
  // R9
  hits_cleared_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(brkReq) |-> hitStatus == '0);
endmodule

// File: tb/addr_break_unit_bench.sv
module addr_break_unit_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic [23:0] cpuAddr = '0;
  logic        linearMode = 1'b1;
  logic [7:0]  pageBase = '0;
  logic        firstFetch = 1'b0;
  logic        instrEnd = 1'b0;
  logic        brkAck = 1'b0;
  logic        brkReq;
  logic [3:0]  hitStatus;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic       brk;
    logic [3:0] hits;
    string      tag;
  } expItem_t;
  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_break_unit u_addr_break_unit (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .cpuAddr(cpuAddr), .linearMode(linearMode),
    .pageBase(pageBase), .firstFetch(firstFetch), .instrEnd(instrEnd),
    .brkAck(brkAck), .brkReq(brkReq), .hitStatus(hitStatus)
  );

  // monitor: compare each clocked result away from the edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      checks++;
      if (brkReq !== e.brk || hitStatus !== e.hits) begin
        failures++;
        $display("FAIL %s: brkReq=%b hitStatus=%b expected brkReq=%b hitStatus=%b",
                 e.tag, brkReq, hitStatus, e.brk, e.hits);
      end
    end
  end

  // driver: one clock with the current inputs, push the expectation, return to idle
  task automatic cyc(input logic eb, input logic [3:0] eh, input string tag);
    @(posedge clk);
    #1;
    expQ.push_back('{eb, eh, tag});
    regWrEn = 1'b0; firstFetch = 1'b0; instrEnd = 1'b0; brkAck = 1'b0;
    cpuAddr = 24'h000000;
  endtask

  task automatic wrReg(input logic [3:0] a, input logic [7:0] d,
                       input logic eb, input logic [3:0] eh, input string tag);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    cyc(eb, eh, tag);
  endtask

  task automatic loadSet(input int s, input logic [23:0] v);
    wrReg(4'(3*s),   v[7:0],   1'b0, 4'h0, "R1");
    wrReg(4'(3*s+1), v[15:8],  1'b0, 4'h0, "R1");
    wrReg(4'(3*s+2), v[23:16], 1'b0, 4'h0, "R1");
  endtask

  task automatic access(input logic [23:0] a, input logic ff, input logic ie,
                        input logic eb, input logic [3:0] eh, input string tag);
    cpuAddr = a; firstFetch = ff; instrEnd = ie;
    cyc(eb, eh, tag);
  endtask

  task automatic ack(input string tag);
    brkAck = 1'b1;
    cyc(1'b0, 4'h0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2);
    checks++;
    if (brkReq !== 1'b0 || hitStatus !== 4'h0) begin
      failures++;
      $display("FAIL R3: reset brkReq=%b hitStatus=%b expected 0 0", brkReq, hitStatus);
    end
    @(posedge clk); #1; rstN = 1'b1;

    loadSet(0, 24'h123456);
    loadSet(1, 24'hAB1234);
    loadSet(2, 24'h00BEEF);
    loadSet(3, 24'h7F0010);
    // R3: control resets to zero, so sets are disabled
    access(24'h123456, 1'b1, 1'b0, 1'b0, 4'h0, "R3");
    wrReg(4'd12, 8'h0F, 1'b0, 4'h0, "R2");

    // R4/R6: linear first-fetch match breaks at once
    access(24'h123456, 1'b1, 1'b0, 1'b1, 4'b0001, "R6");
    cyc(1'b1, 4'b0001, "R9");
    access(24'hAB1234, 1'b1, 1'b0, 1'b1, 4'b0001, "R10");
    ack("R9");
    cyc(1'b0, 4'h0, "R10");

    // R7: deferred to instruction end
    access(24'h7F0010, 1'b0, 1'b0, 1'b0, 4'h0, "R7");
    cyc(1'b0, 4'h0, "R7");
    instrEnd = 1'b1;
    cyc(1'b1, 4'b1000, "R7");
    ack("R9");
    access(24'hAB1234, 1'b0, 1'b1, 1'b1, 4'b0010, "R7");
    ack("R9");

    // R8/R10: two deferred matches merge into one request
    access(24'h123456, 1'b0, 1'b0, 1'b0, 4'h0, "R8");
    access(24'h7F0010, 1'b0, 1'b0, 1'b0, 4'h0, "R10");
    instrEnd = 1'b1;
    cyc(1'b1, 4'b1001, "R8");
    ack("R9");

    // R5: compatibility mode builds {pageBase, low 16}
    linearMode = 1'b0; pageBase = 8'h00;
    access(24'hFFBEEF, 1'b1, 1'b0, 1'b1, 4'b0100, "R5");
    ack("R9");
    pageBase = 8'h12;
    access(24'h003456, 1'b1, 1'b0, 1'b1, 4'b0001, "R5");
    ack("R9");
    linearMode = 1'b1; pageBase = 8'h00;
    access(24'hFFBEEF, 1'b1, 1'b0, 1'b0, 4'h0, "R4");

    // R2: disable set 2, unused offset has no effect
    wrReg(4'd12, 8'h0B, 1'b0, 4'h0, "R2");
    access(24'h00BEEF, 1'b1, 1'b0, 1'b0, 4'h0, "R2");
    wrReg(4'd13, 8'hFF, 1'b0, 4'h0, "R2");
    access(24'h00BEEF, 1'b1, 1'b0, 1'b0, 4'h0, "R2");
    wrReg(4'd12, 8'h0F, 1'b0, 4'h0, "R2");

    // R1: rewrite only the high byte of set 3
    wrReg(4'd10, 8'h55, 1'b0, 4'h0, "R1");
    access(24'h7F0010, 1'b1, 1'b0, 1'b0, 4'h0, "R1");
    access(24'h7F5510, 1'b1, 1'b0, 1'b1, 4'b1000, "R1");
    ack("R9");

    // R11: reset cancels a deferred break
    access(24'h123456, 1'b0, 1'b0, 1'b0, 4'h0, "R11");
    rstN = 1'b0;
    cyc(1'b0, 4'h0, "R11");
    rstN = 1'b1;
    instrEnd = 1'b1;
    cyc(1'b0, 4'h0, "R11");
    // R3: set 0 address reset to zero
    wrReg(4'd12, 8'h01, 1'b0, 4'h0, "R3");
    access(24'h000000, 1'b1, 1'b0, 1'b1, 4'b0001, "R3");
    ack("R9");

    @(negedge clk); @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule